// File: doc/BRIEF.md
# Three-Wire Serial Configuration Port

This block is the configuration slave of a radio front end. A host drives three wires: a bit clock, a data line and an active-low select. While select is low, every rising edge of the bit clock pushes one data bit, most significant first, into a shift register. When select returns high, the final bit shifted decides which of two configuration words is written. The preceding bits are copied into that word's holding register. The other word keeps its value.

The two words differ in length. The channel word carries 23 data bits: divider codes, oscillator selection, modulation filter and compensation controls, oscillator pretune and charge-pump current. The setup word carries 13 data bits: output power, a DAC code shared by the demodulator and ramp paths, the compensation setting and a test-output selector. No bit counter is kept. The port holds only the most recent bits, so any leading excess drops out. All three wires are synchronised into the system clock and edges are detected there. Each field is presented as a parallel output. A few fields are also given in decoded form.

Top module: `cfg3w_port`

## Requirements
- R1: During and after reset every raw field output is 0. The filter enable and the compensation enable are therefore off. The decoded outputs read reference divide 3, main divide 40 and charge-pump step -1.
- R2: A bit is taken only on a rising edge of `sclk_i` seen while `sen_n_i` is low. Bits arrive most significant first.
- R3: Edges on `sclk_i` and changes on `sdat_i` while `sen_n_i` is high leave every output unchanged.
- R4: A low-to-high transition of `sen_n_i` commits the transfer. If the last bit shifted is 1, the channel word is written. If it is 0, the setup word is written. The word that is not addressed keeps its value.
- R5: When more bits arrive than a word needs, the excess leading bits are discarded. Only the trailing 24 bits count for the channel word and the trailing 14 bits for the setup word. The number of pulses is never checked.
- R6: A high-to-low transition of `sen_n_i` clears the shift register. A transfer with fewer bits than the word needs fills the missing upper bits with 0.
- R7: The channel data bits d22..d0, shifted before the address bit, map as follows:
  - d22:21 → `ref_code_o`
  - d20:16 → `swallow_o`
  - d15:13 → `main_code_o`
  - d12 → `vco_tx_sel_o`
  - d11 → ignored
  - d10 → `mcc_en_o`
  - d9:7 → `gauss_dev_o`
  - d6:3 → `pretune_o`
  - d2:1 → `cp_code_o`
  - d0 → `gauss_en_o`
- R8: The setup data bits e12..e0 map as follows:
  - e12:11 → `pwr_lvl_o`
  - e10:6 → `shared_dac_o`
  - e5:3 → `comp_set_o`
  - e2:0 → `test_sel_o`
- R9: `cp_step_o` is the signed value of `cp_code_o` minus 1. Codes 0, 1, 2 and 3 give -1, 0, +1 and +2.
- R10: `ref_div_o` maps reference code 0, 1, 2, 3 to 3, 4, 6, 8. `main_div_o` equals 40 plus `main_code_o`.
- R11: The new field values appear on the third rising edge of `clk` after the first edge that samples `sen_n_i` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial bit clock |
| sdat_i | input | 1 | Serial data |
| sen_n_i | input | 1 | Active-low transfer select |
| ref_code_o | output | 2 | Reference divider code |
| ref_div_o | output | 4 | Decoded reference divide ratio |
| swallow_o | output | 5 | Swallow counter value |
| main_code_o | output | 3 | Main counter code |
| main_div_o | output | 6 | Decoded main divide ratio |
| vco_tx_sel_o | output | 1 | 1 selects the transmit oscillator |
| mcc_en_o | output | 1 | Modulation compensation enable |
| gauss_dev_o | output | 3 | Gaussian filter deviation setting |
| pretune_o | output | 4 | Oscillator pretune DAC code |
| cp_code_o | output | 2 | Charge-pump current code |
| cp_step_o | output | 3 | Signed charge-pump step offset |
| gauss_en_o | output | 1 | Gaussian filter enable |
| pwr_lvl_o | output | 2 | Output power level code |
| shared_dac_o | output | 5 | Demodulator/ramp DAC code |
| comp_set_o | output | 3 | Compensation strength setting |
| test_sel_o | output | 3 | Test output selector |

## Verification
The port is driven with several kinds of transfer:
- A full-length channel transfer and a full-length setup transfer check the field maps and show that the word not addressed keeps its value.
- Over-length transfers of both words separate "keep the last bits" from "keep the first bits".
- A short setup transfer separates clear-on-select from a stale shift register.
- Bit-clock and data activity with select high must change nothing.
- A sweep of charge-pump and reference codes covers every decoded value.

A cycle-accurate model compares every output on every system clock. This pins the commit latency to its exact cycle.

// File: rtl/cfg3w_pkg.sv
package cfg3w_pkg;
  localparam int unsigned CH_BITS  = 23;
  localparam int unsigned SU_BITS  = 13;
  localparam int unsigned SR_BITS  = CH_BITS + 1;
  localparam int unsigned BUS_WIRES = 3;

  typedef struct packed {
    logic [1:0] ref_code;
    logic [4:0] swallow;
    logic [2:0] main_code;
    logic       vco_tx;
    logic       spare;
    logic       mcc_en;
    logic [2:0] gdev;
    logic [3:0] pretune;
    logic [1:0] cp_code;
    logic       gf_en;
  } chan_word_t;

  typedef struct packed {
    logic [1:0] pwr;
    logic [4:0] dac;
    logic [2:0] comp;
    logic [2:0] test;
  } setup_word_t;
endpackage

// File: rtl/cfg3w_rst_sync.sv
module cfg3w_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sn = chain_q[STAGES-1];
endmodule

// File: rtl/cfg3w_sync.sv
module cfg3w_sync #(
  parameter int unsigned          WIDTH   = 3,
  parameter int unsigned          STAGES  = 2,
  parameter logic [WIDTH-1:0]     RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stg_d;
    if (s == 0) begin : g_first
      always_comb stg_d = async_i;
    end else begin : g_next
      always_comb stg_d = stg_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= RST_VAL;
      else        stg_q[s] <= stg_d;
    end
  end

  assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/cfg3w_shift.sv
module cfg3w_shift
  import cfg3w_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               s_clk,
  input  logic               s_dat,
  input  logic               s_en_n,
  output logic [SR_BITS-1:0] sr_o,
  output logic               commit_o
);
  logic               clk_q, en_q;
  logic [SR_BITS-1:0] sr_q, sr_d;
  logic               rise, start;

  always_comb begin
    rise     = s_clk & ~clk_q & ~s_en_n;
    start    = ~s_en_n & en_q;
    commit_o = s_en_n & ~en_q;
    sr_d     = sr_q;
    if (start)     sr_d = '0;
    else if (rise) sr_d = {sr_q[SR_BITS-2:0], s_dat};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_q <= 1'b0;
      en_q  <= 1'b1;
      sr_q  <= '0;
    end else begin
      clk_q <= s_clk;
      en_q  <= s_en_n;
      sr_q  <= sr_d;
    end
  end

  assign sr_o = sr_q;

  // R3: nothing moves while select stays high
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (s_en_n && en_q) |=> $stable(sr_q));
  // R6: falling select empties the register
  p_clear_on_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_en_n && en_q) |=> (sr_q == '0));
  // R2: a qualified rising edge enters the sampled bit at the bottom
  p_shift_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (s_clk && !clk_q && !s_en_n && !en_q) |=> (sr_q[0] == $past(s_dat)));
endmodule

// File: rtl/cfg3w_regs.sv
module cfg3w_regs
  import cfg3w_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SR_BITS-1:0] sr_i,
  input  logic               commit_i,
  output chan_word_t         chan_o,
  output setup_word_t        setup_o
);
  chan_word_t  chan_q, chan_d;
  setup_word_t setup_q, setup_d;
  logic        ld_chan, ld_setup;

  always_comb begin
    ld_chan  = commit_i &  sr_i[0];
    ld_setup = commit_i & ~sr_i[0];
    chan_d   = ld_chan  ? chan_word_t'(sr_i[CH_BITS:1])  : chan_q;
    setup_d  = ld_setup ? setup_word_t'(sr_i[SU_BITS:1]) : setup_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q  <= '0;
      setup_q <= '0;
    end else begin
      chan_q  <= chan_d;
      setup_q <= setup_d;
    end
  end

  assign chan_o  = chan_q;
  assign setup_o = setup_q;

  // R4: an unaddressed word never changes
  p_chan_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit_i && sr_i[0]) |=> $stable(chan_q));
  p_setup_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit_i && !sr_i[0]) |=> $stable(setup_q));
  // R7: the channel word takes the bits above the address
  p_chan_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && sr_i[0]) |=> (chan_q == $past(sr_i[CH_BITS:1])));
endmodule

// File: rtl/cfg3w_port.sv
module cfg3w_port
  import cfg3w_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              sdat_i,
  input  logic              sen_n_i,
  output logic [1:0]        ref_code_o,
  output logic [3:0]        ref_div_o,
  output logic [4:0]        swallow_o,
  output logic [2:0]        main_code_o,
  output logic [5:0]        main_div_o,
  output logic              vco_tx_sel_o,
  output logic              mcc_en_o,
  output logic [2:0]        gauss_dev_o,
  output logic [3:0]        pretune_o,
  output logic [1:0]        cp_code_o,
  output logic signed [2:0] cp_step_o,
  output logic              gauss_en_o,
  output logic [1:0]        pwr_lvl_o,
  output logic [4:0]        shared_dac_o,
  output logic [2:0]        comp_set_o,
  output logic [2:0]        test_sel_o
);
  localparam logic [BUS_WIRES-1:0] BUS_IDLE = 3'b100;
  localparam logic [5:0]           MAIN_BASE = 6'd40;

  logic                 rst_sn;
  logic [BUS_WIRES-1:0] bus_s;
  logic [SR_BITS-1:0]   sr;
  logic                 commit;
  chan_word_t           chan;
  setup_word_t          setup;
  logic                 unused_spare;

  cfg3w_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sn(rst_sn));

  cfg3w_sync #(.WIDTH(BUS_WIRES), .STAGES(SYNC_STAGES), .RST_VAL(BUS_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_sn),
    .async_i({sen_n_i, sdat_i, sclk_i}), .sync_o(bus_s));

  cfg3w_shift u_shift (
    .clk(clk), .rst_n(rst_sn),
    .s_clk(bus_s[0]), .s_dat(bus_s[1]), .s_en_n(bus_s[2]),
    .sr_o(sr), .commit_o(commit));

  cfg3w_regs u_regs (
    .clk(clk), .rst_n(rst_sn), .sr_i(sr), .commit_i(commit),
    .chan_o(chan), .setup_o(setup));

  always_comb begin
    unique case (chan.ref_code)
      2'd0:    ref_div_o = 4'd3;
      2'd1:    ref_div_o = 4'd4;
      2'd2:    ref_div_o = 4'd6;
      default: ref_div_o = 4'd8;
    endcase
    main_div_o = MAIN_BASE + {3'b000, chan.main_code};
    cp_step_o  = $signed({1'b0, chan.cp_code}) - 3'sd1;
  end

  assign unused_spare = chan.spare;
  assign ref_code_o   = chan.ref_code;
  assign swallow_o    = chan.swallow;
  assign main_code_o  = chan.main_code;
  assign vco_tx_sel_o = chan.vco_tx;
  assign mcc_en_o     = chan.mcc_en;
  assign gauss_dev_o  = chan.gdev;
  assign pretune_o    = chan.pretune;
  assign cp_code_o    = chan.cp_code;
  assign gauss_en_o   = chan.gf_en;
  assign pwr_lvl_o    = setup.pwr;
  assign shared_dac_o = setup.dac;
  assign comp_set_o   = setup.comp;
  assign test_sel_o   = setup.test;

  // R9: offset always within the four legal steps
  p_cp_range_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    (cp_step_o >= -3'sd1) && (cp_step_o <= 3'sd2) && (cp_step_o != -3'sd4));
  // R1: enables off coming out of reset
  p_reset_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_sn) |-> (!gauss_en_o && !mcc_en_o));
endmodule

// File: tb/cfg3w_port_tb_top.sv
module cfg3w_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdat = 1'b0, sen_n = 1'b1;

  logic [1:0] ref_code; logic [3:0] ref_div; logic [4:0] swallow;
  logic [2:0] main_code; logic [5:0] main_div; logic vco_tx, mcc_en;
  logic [2:0] gdev; logic [3:0] pretune; logic [1:0] cp_code;
  logic signed [2:0] cp_step; logic gf_en; logic [1:0] pwr;
  logic [4:0] dac; logic [2:0] comp, tsel;

  int compared = 0, mismatched = 0, cycles = 0;
  string cur_req = "R1";

  logic [23:0] srm;
  logic [22:0] e1 = '0, e1_next = '0;
  logic [12:0] e2 = '0, e2_next = '0;
  logic        addr_next = 1'b0;
  int          pend = 0;

  always #10 clk = ~clk;

  cfg3w_port dut_i (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdat_i(sdat), .sen_n_i(sen_n),
    .ref_code_o(ref_code), .ref_div_o(ref_div), .swallow_o(swallow),
    .main_code_o(main_code), .main_div_o(main_div), .vco_tx_sel_o(vco_tx),
    .mcc_en_o(mcc_en), .gauss_dev_o(gdev), .pretune_o(pretune),
    .cp_code_o(cp_code), .cp_step_o(cp_step), .gauss_en_o(gf_en),
    .pwr_lvl_o(pwr), .shared_dac_o(dac), .comp_set_o(comp), .test_sel_o(tsel));

  task automatic chk(string name, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", cur_req, name, act, exp, cycles);
    end
  endtask

  function automatic int ref_ratio(logic [1:0] c);
    case (c) 2'd0: return 3; 2'd1: return 4; 2'd2: return 6; default: return 8; endcase
  endfunction

  task automatic tick();
    @(negedge clk);
    cycles++;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        if (addr_next) e1 = e1_next; else e2 = e2_next;
      end
    end
    chk("ref_code", ref_code, e1[22:21]);
    chk("ref_div", ref_div, ref_ratio(e1[22:21]));
    chk("swallow", swallow, e1[20:16]);
    chk("main_code", main_code, e1[15:13]);
    chk("main_div", main_div, 40 + e1[15:13]);
    chk("vco_tx", vco_tx, e1[12]);
    chk("mcc_en", mcc_en, e1[10]);
    chk("gdev", gdev, e1[9:7]);
    chk("pretune", pretune, e1[6:3]);
    chk("cp_code", cp_code, e1[2:1]);
    chk("cp_step", cp_step, int'(e1[2:1]) - 1);
    chk("gf_en", gf_en, e1[0]);
    chk("pwr", pwr, e2[12:11]);
    chk("dac", dac, e2[10:6]);
    chk("comp", comp, e2[5:3]);
    chk("test", tsel, e2[2:0]);
  endtask

  // Send n bits of v, MSB first; model: clear on select, shift, commit on release.
  task automatic xfer(input logic [63:0] v, input int n);
    sen_n = 1'b0; srm = '0;
    repeat (4) tick();
    for (int i = n - 1; i >= 0; i--) begin
      sclk = 1'b0; sdat = v[i];
      repeat (3) tick();
      sclk = 1'b1; srm = {srm[22:0], v[i]};
      repeat (3) tick();
    end
    sclk = 1'b0;
    repeat (3) tick();
    sen_n = 1'b1;
    addr_next = srm[0];
    e1_next = srm[23:1];
    e2_next = srm[13:1];
    pend = 3;                 // R11: visible on the third edge
    repeat (8) tick();
  endtask

  initial begin
    repeat (5) tick();        // R1: reset values while held
    rst_n = 1'b1;
    repeat (6) tick();        // R1: after release

    cur_req = "R7";           // R2 R4 R7 R9 R10: full channel word
    xfer({40'd0, 23'h5A3C96, 1'b1}, 24);
    cur_req = "R8";           // R4 R8: setup word, channel untouched
    xfer({50'd0, 13'h1B5E, 1'b0}, 14);

    cur_req = "R3";           // bus clock and data toggling with select high
    for (int k = 0; k < 10; k++) begin
      sdat = k[0]; sclk = 1'b1; repeat (3) tick();
      sclk = 1'b0; repeat (3) tick();
    end

    cur_req = "R5";           // 30-bit channel transfer, leading junk
    xfer({34'd0, 6'b111111, 23'h12ABCD, 1'b1}, 30);
    cur_req = "R5";           // 20-bit setup transfer
    xfer({44'd0, 6'b101101, 13'h0A53, 1'b0}, 20);

    cur_req = "R6";           // short setup transfer, zero fill
    xfer({58'd0, 5'b10111, 1'b0}, 6);

    cur_req = "R9";           // R9 R10 sweep of charge-pump and reference codes
    for (int c = 0; c < 4; c++) begin
      logic [22:0] w;
      w = {c[1:0], 5'd31, c[2:0] + 3'd4, 1'b1, 1'b0, 1'b1, 3'd5, 4'd9, c[1:0], c[0]};
      xfer({40'd0, w, 1'b1}, 24);
    end

    cur_req = "R11";          // back-to-back words of both kinds
    xfer({40'd0, 23'h7FFFFF, 1'b1}, 24);
    xfer({50'd0, 13'h1FFF, 1'b0}, 14);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog (all requirements): actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule